// File: doc/BRIEF.md
# Program and Erase Sequencer with Status Readout

This block carries out write and erase operations on a small synchronous byte array that stands in for nonvolatile cells. A command decoder upstream hands it one request at a time: program one byte, erase one sector, or erase the whole array. Each operation is timed by an internal counter, so the host only issues the request and then watches the read port.

While an operation runs, any read returns a status byte instead of array data. Bit 7 is a polling bit, bit 6 flips on every status read, and bit 5 flags an operation that did not reach its target. Programming can only pull bits from 1 to 0. A whole-array erase first clears every byte to 00h, then waits out the erase time, then sets every byte to FFh. A failed program holds the engine in a failed state until the host sends a return-to-read request.

Top module: `ppe_engine`

## Requirements
- R1: After reset, busy is 0 and every byte reads FFh. A read presented with rd_en at one clock edge appears on rd_data after that edge.
- R2: A program request (cmd_op = 01) accepted while idle holds busy high for exactly PROG_CYC cycles. Afterwards a read of the target returns the stored byte.
- R3: Programming stores the bitwise AND of the previous byte and the request data, so no bit ever goes from 0 to 1.
- R4: A read sampled while busy returns the status byte. Bits 4 to 0 are 0. Bit 7 is the complement of bit 7 of the program data during a program, and 0 during either erase.
- R5: Bit 6 of the status byte changes value on each status read, starting from 0 after reset.
- R6: If a program's stored result differs from the request data, the engine stays busy when the timer ends, with status bit 5 set. It stays in this failed state until reset_cmd is seen, and busy is 0 one cycle after that.
- R7: A sector erase (cmd_op = 11) selects its sector by the top SECT_BITS address bits. It sets that sector's bytes to FFh, leaves every other byte untouched, and holds busy for ERASE_CYC plus the sector size in cycles.
- R8: A chip erase (cmd_op = 10) holds busy for exactly 2 x DEPTH + ERASE_CYC cycles: one clearing pass, the erase wait, and one fill pass. It leaves every byte at FFh.
- R9: Requests that arrive while busy, including in the failed state, are ignored. The same holds for cmd_op = 00 at any time.
- R10: busy falls on the same edge as the last array write, so a read issued in the first idle cycle returns the final content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request strobe |
| cmd_op | input | 2 | 00 none, 01 program, 10 chip erase, 11 sector erase |
| cmd_addr | input | ADDR_W | Target byte, or any byte of the target sector |
| cmd_data | input | 8 | Program data |
| reset_cmd | input | 1 | Return-to-read request that clears the failed state |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered array byte or status byte |
| busy | output | 1 | Operation in progress or failed |

## Verification
The length of busy is the main timing result. Busy rises one edge after the request edge and stays high for PROG_CYC, ERASE_CYC plus the sector size, or 2 x DEPTH + ERASE_CYC cycles. The bench counts busy cycles at falling edges and compares the count with these totals. Read results arrive one edge after the read strobe. The driver pushes the expected byte when it issues the read, choosing status or array data from the busy level at that moment, and the monitor pops and compares it at the next falling edge. Array contents are checked in the first idle cycle after busy falls, which is the point at which R10 says the data is ready.

// File: rtl/ppe_pkg.sv
package ppe_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_CHIP = 2'd2,
        OP_SECT = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROG,
        S_PRE,
        S_EWAIT,
        S_FILL,
        S_FAIL
    } st_e;

    localparam logic [7:0] ERASED  = 8'hFF;
    localparam logic [7:0] CLEARED = 8'h00;

    typedef struct packed {
        logic       poll;
        logic       tog;
        logic       tmo;
        logic [4:0] pad;
    } stat_t;

    function automatic logic [7:0] pack_status(input logic poll, input logic tog, input logic tmo);
        stat_t s;
        s.poll = poll;
        s.tog  = tog;
        s.tmo  = tmo;
        s.pad  = '0;
        return s;
    endfunction

endpackage

// File: rtl/ppe_timer.sv
module ppe_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
    end

    assign zero = (cnt_q == '0);

    // R2: once expired and not reloaded, the timer stays expired
    a_r2_timer_hold: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);

endmodule

// File: rtl/ppe_seq.sv
module ppe_seq
    import ppe_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SECT_BITS = 2,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              reset_cmd,
    input  logic [7:0]        cell_q,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              poll_bit,
    output logic              tmo_bit
);
    localparam int SECT_SZ_W = ADDR_W - SECT_BITS;
    localparam int MAXCYC    = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int TW        = $clog2(MAXCYC + 1);
    localparam logic [TW-1:0]     PROG_LOAD  = TW'(PROG_CYC - 1);
    localparam logic [TW-1:0]     ERASE_LOAD = TW'(ERASE_CYC - 1);
    localparam logic [ADDR_W-1:0] ONE_A      = ADDR_W'(1);

    st_e               st_q;
    op_e               op_q;
    op_e               cmd_kind;
    logic [ADDR_W-1:0] tgt_q;
    logic [ADDR_W-1:0] walk_q;
    logic [ADDR_W-1:0] walk_end;
    logic [7:0]        pdat_q;
    logic [7:0]        merged;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_zero;

    assign cmd_kind = op_e'(cmd_op);
    assign merged   = cell_q & pdat_q;
    assign walk_end = (op_q == OP_CHIP) ? '1
                                        : {tgt_q[ADDR_W-1 -: SECT_BITS], {SECT_SZ_W{1'b1}}};

    ppe_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = ERASE_LOAD;
        wr_en    = 1'b0;
        wr_addr  = walk_q;
        wr_data  = ERASED;
        case (st_q)
            S_IDLE: begin
                if (cmd_valid && cmd_kind == OP_PROG) begin
                    tmr_load = 1'b1;
                    tmr_val  = PROG_LOAD;
                end else if (cmd_valid && cmd_kind == OP_SECT) begin
                    tmr_load = 1'b1;
                end
            end
            S_PROG: begin
                wr_addr = tgt_q;
                wr_data = merged;
                wr_en   = tmr_zero;
            end
            S_PRE: begin
                wr_en    = 1'b1;
                wr_data  = CLEARED;
                tmr_load = (walk_q == '1);
            end
            S_FILL: begin
                wr_en   = 1'b1;
                wr_data = ERASED;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            op_q   <= OP_NONE;
            tgt_q  <= '0;
            walk_q <= '0;
            pdat_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (cmd_valid && cmd_kind != OP_NONE) begin
                        op_q   <= cmd_kind;
                        tgt_q  <= cmd_addr;
                        pdat_q <= cmd_data;
                        case (cmd_kind)
                            OP_PROG: st_q <= S_PROG;
                            OP_CHIP: begin
                                st_q   <= S_PRE;
                                walk_q <= '0;
                            end
                            default: begin
                                st_q   <= S_EWAIT;
                                walk_q <= {cmd_addr[ADDR_W-1 -: SECT_BITS], {SECT_SZ_W{1'b0}}};
                            end
                        endcase
                    end
                end
                S_PROG: begin
                    if (tmr_zero) st_q <= (merged == pdat_q) ? S_IDLE : S_FAIL;
                end
                S_PRE: begin
                    walk_q <= walk_q + ONE_A;
                    if (walk_q == '1) st_q <= S_EWAIT;
                end
                S_EWAIT: begin
                    if (tmr_zero) st_q <= S_FILL;
                end
                S_FILL: begin
                    walk_q <= walk_q + ONE_A;
                    if (walk_q == walk_end) st_q <= S_IDLE;
                end
                S_FAIL: begin
                    if (reset_cmd) st_q <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != S_IDLE);
    assign tmo_bit  = (st_q == S_FAIL);
    assign poll_bit = (op_q == OP_PROG) ? ~pdat_q[7] : 1'b0;

    // R9: a request arriving while busy leaves the latched target untouched
    a_r9_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(tgt_q) && $stable(pdat_q) && $stable(op_q)));

    // R6: the failed state holds until the return-to-read request
    a_r6_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_FAIL && !reset_cmd) |=> (st_q == S_FAIL));

    // R10: busy only falls out of a final write or a failure release
    a_r10_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(st_q == S_PROG || st_q == S_FILL
                              || (st_q == S_FAIL && reset_cmd)));

    // R3: a program write never raises a cleared bit
    a_r3_only_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && st_q == S_PROG) |-> ((wr_data & ~cell_q) == 8'h00));

endmodule

// File: rtl/ppe_array.sv
module ppe_array
    import ppe_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        cell_q,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              status_mode,
    input  logic              poll_bit,
    input  logic              tmo_bit,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];
    logic       tog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign cell_q = mem_q[wr_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            tog_q   <= 1'b0;
        end else if (rd_en) begin
            if (status_mode) begin
                rd_data <= pack_status(poll_bit, tog_q, tmo_bit);
                tog_q   <= ~tog_q;
            end else begin
                rd_data <= mem_q[rd_addr];
            end
        end
    end

    // R5: each status read flips the toggle source
    a_r5_toggle_flip: assert property (@(posedge clk) disable iff (rst)
        (rd_en && status_mode) |=> (tog_q != $past(tog_q)));

    // R1: a plain array read leaves the toggle source alone
    a_r1_plain_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !status_mode) |=> $stable(tog_q));

endmodule

// File: rtl/ppe_engine.sv
module ppe_engine
    import ppe_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SECT_BITS = 2,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              reset_cmd,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [7:0]        cell_q;
    logic              poll_bit;
    logic              tmo_bit;

    ppe_seq #(
        .ADDR_W    (ADDR_W),
        .SECT_BITS (SECT_BITS),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .reset_cmd (reset_cmd),
        .cell_q    (cell_q),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .poll_bit  (poll_bit),
        .tmo_bit   (tmo_bit)
    );

    ppe_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cell_q      (cell_q),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .status_mode (busy),
        .poll_bit    (poll_bit),
        .tmo_bit     (tmo_bit),
        .rd_data     (rd_data)
    );

    // R4: status bytes carry zeros in their low five bits
    a_r4_status_low: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> (rd_data[4:0] == 5'b0));

endmodule

// File: tb/sim_ppe_engine.sv
`timescale 1ns/1ps
module sim_ppe_engine;
    localparam int AW    = 6;
    localparam int SB    = 2;
    localparam int PC    = 8;
    localparam int EC    = 20;
    localparam int DEPTH = 1 << AW;
    localparam int SSZ   = 1 << (AW - SB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic          reset_cmd = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;

    always #2.5 clk = ~clk;

    ppe_engine #(.ADDR_W(AW), .SECT_BITS(SB), .PROG_CYC(PC), .ERASE_CYC(EC)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .reset_cmd(reset_cmd),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] model [DEPTH];
    logic       tog_m    = 1'b0;
    logic       cur_poll = 1'b0;
    logic       cur_fail = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t exp_q[$];

    function automatic void check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    function automatic void check_int(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    // monitor: a read strobed at a rising edge is compared at the next falling edge
    logic rd_pend = 1'b0;
    always @(posedge clk) rd_pend <= rd_en;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check_int("R1 scoreboard underflow", 0, 1);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check8(it.tag, rd_data, it.exp);
            end
        end
    end

    // driver: one read per cycle, expectation chosen from the busy level
    task automatic issue_read(input int a, input string tag);
        item_t it;
        if (busy) begin
            it.exp = {cur_poll, tog_m, cur_fail, 5'b0};
            tog_m  = ~tog_m;
        end else begin
            it.exp = model[a];
        end
        it.tag = tag;
        exp_q.push_back(it);
        rd_en   = 1'b1;
        rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] op, input int a, input logic [7:0] d,
                          input int exp_cyc, input int limit, input int nreads,
                          input int raddr, input logic pollb, input bit inject,
                          input string tag);
        int cnt;
        cur_poll  = pollb;
        cur_fail  = 1'b0;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = AW'(a);
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        cnt = 0;
        while (busy && cnt < limit) begin
            if (inject && cnt == 2) begin
                cmd_valid = 1'b1;
                cmd_op    = 2'b01;
                cmd_addr  = AW'(40);
                cmd_data  = 8'h00;
            end else begin
                cmd_valid = 1'b0;
            end
            if (cnt < nreads) issue_read(raddr, {tag, " R4 R5 status"});
            else @(negedge clk);
            cnt++;
        end
        cmd_valid = 1'b0;
        check_int({tag, " busy cycles"}, cnt, exp_cyc);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_int("R1 busy after reset", int'(busy), 0);
        issue_read(0, "R1 erased after reset");
        issue_read(37, "R1 erased after reset");
        issue_read(63, "R1 erased after reset");

        // R9 op code 00 is ignored
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = AW'(5); cmd_data = 8'h00;
        @(negedge clk);
        cmd_valid = 1'b0;
        check_int("R9 no-op request busy", int'(busy), 0);
        issue_read(5, "R9 no-op left data");

        // R2 program, poll bit 0 during the operation
        run_op(2'b01, 5, 8'hA5, PC, 100, 5, 5, 1'b0, 1'b0, "R2");
        model[5] = model[5] & 8'hA5;
        issue_read(5, "R2 R10 programmed byte");

        // R4 program with data bit 7 clear, poll bit reads 1
        run_op(2'b01, 20, 8'h3C, PC, 100, 4, 20, 1'b1, 1'b0, "R4");
        model[20] = model[20] & 8'h3C;
        issue_read(20, "R4 programmed byte");

        // R6 program that cannot reach its data: fails and holds
        run_op(2'b01, 5, 8'h0F, PC + 6, PC + 6, 0, 5, 1'b1, 1'b0, "R6");
        model[5] = model[5] & 8'h0F;
        cur_fail = 1'b1;
        issue_read(5, "R6 failed status");
        issue_read(9, "R6 failed status");
        issue_read(5, "R6 failed status");
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = AW'(41); cmd_data = 8'h00;
        @(negedge clk);
        cmd_valid = 1'b0;
        check_int("R9 request in failed state busy", int'(busy), 1);
        reset_cmd = 1'b1;
        @(negedge clk);
        reset_cmd = 1'b0;
        cur_fail  = 1'b0;
        check_int("R6 busy after reset_cmd", int'(busy), 0);
        issue_read(5, "R3 AND of old and new");
        issue_read(41, "R9 ignored program in failed state");

        // R3 program that only clears bits succeeds
        run_op(2'b01, 5, 8'h01, PC, 100, 0, 5, 1'b1, 1'b0, "R3");
        model[5] = model[5] & 8'h01;
        issue_read(5, "R3 cleared bits");

        // R7 sector erase of sector 0 with a request injected while busy
        run_op(2'b11, 3, 8'h00, EC + SSZ, 200, 4, 5, 1'b0, 1'b1, "R7");
        for (int i = 0; i < SSZ; i++) model[i] = 8'hFF;
        issue_read(5, "R7 R10 sector erased");
        issue_read(20, "R7 other sector kept");
        issue_read(40, "R9 injected program ignored");

        // R8 chip erase
        run_op(2'b10, 0, 8'h00, 2 * DEPTH + EC, 400, 3, 63, 1'b0, 1'b0, "R8");
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        issue_read(20, "R8 R10 chip erased");
        issue_read(63, "R8 chip erased");

        // R10 program at the top address, read in the first idle cycle
        run_op(2'b01, 63, 8'h00, PC, 100, 2, 63, 1'b1, 1'b0, "R10");
        model[63] = 8'h00;
        issue_read(63, "R10 first idle read");

        repeat (3) @(negedge clk);
        check_int("R1 scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule